// File: doc/BRIEF.md
# Time-Slot Interchange Switch Core

This block is a non-blocking time-slot switch for four serial streams. Each stream has 32 eight-bit channels, and together they carry 128 channels. A 128-entry byte store holds the latest byte of every input channel. The input deserialiser writes this store through a simple write port. For each output channel, a connection store gives the rule for that channel. The rule has two parts: a byte entry and a small control entry. In switched mode the byte entry names the source stream and channel, and the addressed stored byte is sent. In message mode the byte entry itself is sent, and it repeats every frame until it is rewritten.

Each output channel has its own driver enable. A chip-level drive-enable pin can force every output into high impedance. A broadcast input puts every channel into driving message mode, whatever its control entry holds.

One clock cycle is one bit cell. A frame is 32 channels of 8 cells each, so it lasts 256 cycles. A frame-sync input restarts the frame count. Each output is given as a data bit and an enable bit, and a surrounding pad ring turns these into tri-state pins.

Top module: `tsi_switch`

## Requirements
- R1: Each stream frame has 256 bit cells: 32 channels of 8 cells, one cell per clock. When `frame_sync` is high in a cycle, the next cycle is the first cell of channel 0. Without a sync pulse, channel 0 follows 256 cycles after the previous channel 0.
- R2: In switched mode, an output channel sends the byte-store entry whose address is bits 6:0 of that channel's connection byte entry. Bit 7 of the connection byte entry is ignored. For every address port, bits 6:5 are the stream and bits 4:0 are the channel.
- R3: When bit 2 of a channel's control entry is 1 (message mode), the channel sends its connection byte entry. The same byte is sent every frame until the entry is rewritten, whatever the byte store holds.
- R4: When bit 0 of a channel's control entry is 0, the stream's `ser_oe` is low and `ser_out` is 0 for all 8 cells of that channel. When bit 0 is 1, the channel drives.
- R5: While `ode` is low, all four `ser_oe` bits are low and all `ser_out` bits are 0, whatever the control entries hold.
- R6: While `bcast` is high, every channel acts as if bits 2 and 0 of its control entry were both 1. It drives its connection byte entry.
- R7: Bytes are shifted out MSB first. The byte and the driver enable of a channel are fixed at the start of its first cell and stay constant for its 8 cells.
- R8: After reset, `ser_oe` and `ser_out` are all 0. All stores are cleared, so every channel is high impedance until its control entry is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-cell clock |
| rst_n | input | 1 | Active-low reset |
| frame_sync | input | 1 | Frame restart pulse |
| ode | input | 1 | Chip-level drive enable |
| bcast | input | 1 | Force every channel into driving message mode |
| dm_we | input | 1 | Byte-store write strobe |
| dm_addr | input | 7 | Byte-store address {stream, channel} |
| dm_wdata | input | 8 | Byte-store write data |
| cm_we | input | 1 | Connection-store write strobe |
| cm_hi | input | 1 | 1 writes the control entry (bits 2 and 0), 0 writes the byte entry |
| cm_addr | input | 7 | Output channel address {stream, channel} |
| cm_wdata | input | 8 | Connection-store write data |
| ser_out | output | 4 | Serial data, one bit per stream |
| ser_oe | output | 4 | Driver enable, one bit per stream |

## Verification
The bench maps every output channel to an input channel offset by 37, so each route crosses streams and channel numbers. It sets bit 7 in half of the route entries. A design that decoded bit 7, or swapped the stream and channel fields, would send the wrong bytes. A design that shifted LSB first would send the bits in reverse order.

Message-mode channels are checked again after the whole byte store is overwritten. That frame runs free, without a sync pulse, so a design that let message channels follow the store would fail. So would a design whose frame count did not wrap at 256.

Alternate channels have the driver bit cleared, and further frames are captured with the drive-enable pin low and with broadcast high over cleared control entries. These frames catch a design where a per-channel high-impedance setting or the chip-level enable leaks, or where broadcast does not force both driving and message mode.

// File: rtl/tsi_switch.sv
module tsi_switch #(
  parameter int STREAMS  = 4,
  parameter int CHANNELS = 32,
  parameter int DW       = 8,
  localparam int SW = $clog2(STREAMS),
  localparam int CW = $clog2(CHANNELS),
  localparam int AW = SW + CW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_sync,
  input  logic               ode,
  input  logic               bcast,
  input  logic               dm_we,
  input  logic [AW-1:0]      dm_addr,
  input  logic [DW-1:0]      dm_wdata,
  input  logic               cm_we,
  input  logic               cm_hi,
  input  logic [AW-1:0]      cm_addr,
  input  logic [DW-1:0]      cm_wdata,
  output logic [STREAMS-1:0] ser_out,
  output logic [STREAMS-1:0] ser_oe
);
  localparam int DEPTH = STREAMS * CHANNELS;
  localparam int BW    = $clog2(DW);
  localparam int TW    = CW + BW;

  logic [DW-1:0] dmem [DEPTH];
  logic [DW-1:0] cml  [DEPTH];
  logic [1:0]    cmh  [DEPTH];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        dmem[i] <= '0;
        cml[i]  <= '0;
        cmh[i]  <= '0;
      end
    end else begin
      if (dm_we) dmem[dm_addr] <= dm_wdata;
      if (cm_we && !cm_hi) cml[cm_addr] <= cm_wdata;
      if (cm_we && cm_hi)  cmh[cm_addr] <= {cm_wdata[2], cm_wdata[0]};
    end

  logic [TW-1:0] cnt, nxt;
  logic          load;
  logic [CW-1:0] nch;

  assign nxt  = frame_sync ? '0 : cnt + 1'b1;
  assign load = (nxt[BW-1:0] == '0);
  assign nch  = nxt[TW-1:BW];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt <= '1;
    else        cnt <= nxt;

  logic seen_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;

  logic [DW-1:0] shr_q [STREAMS];
  logic          oe_q  [STREAMS];

  for (genvar s = 0; s < STREAMS; s++) begin : g_stream
    logic [AW-1:0] idx;
    logic [DW-1:0] lo, sel_byte;
    logic          msg, drv;

    assign idx      = {SW'(s), nch};
    assign lo       = cml[idx];
    assign msg      = bcast | cmh[idx][1];
    assign drv      = bcast | cmh[idx][0];
    assign sel_byte = msg ? lo : dmem[lo[AW-1:0]];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        shr_q[s] <= '0;
        oe_q[s]  <= 1'b0;
      end else if (load) begin
        shr_q[s] <= sel_byte;
        oe_q[s]  <= drv;
      end else begin
        shr_q[s] <= {shr_q[s][DW-2:0], 1'b0};
      end

    assign ser_oe[s]  = ode & oe_q[s];
    assign ser_out[s] = ser_oe[s] & shr_q[s][DW-1];

    assert_shift_msb_R7: assert property (@(posedge clk) disable iff (!rst_n)
      seen_q && cnt[BW-1:0] != '0 |-> shr_q[s] == {$past(shr_q[s][DW-2:0]), 1'b0});

    assert_oe_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
      seen_q && cnt[BW-1:0] != '0 |-> $stable(oe_q[s]));

    assert_bcast_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
      seen_q && $past(bcast) && cnt[BW-1:0] == '0 |-> oe_q[s]);
  end

  assert_sync_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q && $past(frame_sync) |-> cnt == '0);

  assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q && !$past(frame_sync) && $past(cnt) == '1 |-> cnt == '0);

  assert_ode_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ode |-> ser_out == '0);
endmodule

// File: tb/test_tsi_switch.sv
module test_tsi_switch;
  logic       clk = 0, rst_n = 0, frame_sync = 0, ode = 1, bcast = 0;
  logic       dm_we = 0, cm_we = 0, cm_hi = 0;
  logic [6:0] dm_addr = 0, cm_addr = 0;
  logic [7:0] dm_wdata = 0, cm_wdata = 0;
  logic [3:0] ser_out, ser_oe;

  int checks = 0, errors = 0;
  logic [7:0] got [4][32];
  logic       en  [4][32];
  logic       quiet [4][32];

  always #5 clk = ~clk;

  tsi_switch i_tsi_switch (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(int a);
    return 8'((a * 29 + 11) ^ 8'hA5);
  endfunction

  task automatic wr_dm(int a, logic [7:0] d);
    dm_we = 1; dm_addr = 7'(a); dm_wdata = d;
    @(negedge clk); dm_we = 0;
  endtask

  task automatic wr_cm(bit hi, int a, logic [7:0] d);
    cm_we = 1; cm_hi = hi; cm_addr = 7'(a); cm_wdata = d;
    @(negedge clk); cm_we = 0;
  endtask

  task automatic capture(bit sync);
    if (sync) begin
      frame_sync = 1; @(negedge clk); frame_sync = 0;
    end
    for (int i = 0; i < 256; i++) begin
      if (i % 8 == 0) begin
        en[i/32][0] = en[i/32][0];
        for (int s = 0; s < 4; s++) begin
          en[s][i/8] = ser_oe[s];
          quiet[s][i/8] = 1'b1;
        end
      end
      for (int s = 0; s < 4; s++) begin
        got[s][i/8][7 - i%8] = ser_out[s];
        if (ser_oe[s] != en[s][i/8]) quiet[s][i/8] = 1'b0;
      end
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk("R8 oe after reset", 32'(ser_oe), 0);
    chk("R8 out after reset", 32'(ser_out), 0);
    capture(1);
    for (int s = 0; s < 4; s++)
      for (int c = 0; c < 32; c++) chk("R8 cleared control", 32'(en[s][c]), 0);
  endtask

  task automatic t_switched;
    for (int a = 0; a < 128; a++) wr_dm(a, pat(a));
    for (int o = 0; o < 128; o++) begin
      wr_cm(0, o, 8'((o + 37) % 128) | (o[0] ? 8'h80 : 8'h00));
      wr_cm(1, o, 8'h01);
    end
    capture(1);
    for (int s = 0; s < 4; s++)
      for (int c = 0; c < 32; c++) begin
        chk("R2 R7 switched byte", 32'(got[s][c]), 32'(pat((s*32 + c + 37) % 128)));
        chk("R4 driving", 32'(en[s][c]), 1);
        chk("R7 enable steady", 32'(quiet[s][c]), 1);
      end
  endtask

  task automatic t_message;
    for (int c = 0; c < 32; c++) begin
      wr_cm(0, 64 + c, 8'hC0 | 8'(c));
      wr_cm(1, 64 + c, 8'h05);
    end
    capture(1);
    for (int c = 0; c < 32; c++) chk("R3 message byte", 32'(got[2][c]), 32'(8'hC0 | 8'(c)));
    for (int a = 0; a < 128; a++) wr_dm(a, 8'hFF);
    repeat (256 - 128) @(negedge clk);
    capture(0);
    for (int c = 0; c < 32; c++) begin
      chk("R3 R1 message repeats", 32'(got[2][c]), 32'(8'hC0 | 8'(c)));
      chk("R2 R1 switched follows store", 32'(got[0][c]), 32'hFF);
    end
  endtask

  task automatic t_hiz;
    for (int c = 0; c < 32; c++) wr_cm(1, 32 + c, c[0] ? 8'h00 : 8'h01);
    capture(1);
    for (int c = 0; c < 32; c++) begin
      chk("R4 channel enable", 32'(en[1][c]), c[0] ? 0 : 1);
      if (c[0]) chk("R4 hiz data zero", 32'(got[1][c]), 0);
    end
  endtask

  task automatic t_ode;
    ode = 0;
    capture(1);
    for (int s = 0; s < 4; s++)
      for (int c = 0; c < 32; c++) begin
        chk("R5 ode low enable", 32'(en[s][c]), 0);
        chk("R5 ode low data", 32'(got[s][c]), 0);
      end
    ode = 1;
  endtask

  task automatic t_bcast;
    for (int o = 0; o < 128; o++) begin
      wr_cm(1, o, 8'h00);
      wr_cm(0, o, 8'(o) ^ 8'h3C);
    end
    bcast = 1;
    capture(1);
    for (int s = 0; s < 4; s++)
      for (int c = 0; c < 32; c++) begin
        chk("R6 broadcast drives", 32'(en[s][c]), 1);
        chk("R6 broadcast message", 32'(got[s][c]), 32'(8'(s*32 + c) ^ 8'h3C));
      end
    bcast = 0;
    capture(1);
    for (int s = 0; s < 4; s++)
      for (int c = 0; c < 32; c++) chk("R6 broadcast released", 32'(en[s][c]), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_switched();
    t_message();
    t_hiz();
    t_ode();
    t_bcast();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule